// File: doc/BRIEF.md
# 68000 Bus Glue Logic Controller

This block sits between a 16-bit 68000-style processor bus and its memories and peripherals, running from the 8 MHz system clock. It watches the address strobe, the two data strobes, the read/write line and the upper 23 address lines. From these it drives active-low chip selects, output enables and write enables for a flash bank and an SRAM bank, split into an even byte lane (upper data byte, D8–D15, gated by the upper data strobe) and an odd byte lane (lower data byte, D0–D7, gated by the lower data strobe). It also drives selects for a byte-wide input port, a byte-wide output port and a serial controller, all of which sit on the odd lane.

Every decoded bus cycle is acknowledged by a registered, active-low data acknowledge that follows the address strobe by a selectable number of wait states. A cycle that hits no region is never acknowledged. Any cycle whose address strobe stays low for 64 clocks gets a bus-error flag instead, held until the strobe rises. A free-running divider, first by 13 and then by 4, turns the 8 MHz clock into a one-clock enable every 52 clocks (about 153.8 kHz). This serves as the 16x bit clock for roughly 9600 baud.

Top module: `bus_glue_ctl`

## Requirements
- R1: The map uses byte addresses. Flash occupies 0x000000–0x07FFFF. Its even-lane select is low only while the address strobe and the upper data strobe are both low and the address is in flash. Its odd-lane select is low only while the address strobe and the lower data strobe are both low and the address is in flash.
- R2: The flash output enable is low only while the address strobe is low, the address is in flash and read/write is high (read).
- R3: SRAM occupies 0x100000–0x17FFFF. Its lane selects follow the lane rule of R1. Its output enable is low only on reads inside SRAM.
- R4: The SRAM even-lane write enable is low only while the address strobe is low, the address is in SRAM, read/write is low and the upper data strobe is low. The odd-lane write enable follows the same rule with the lower data strobe.
- R5: With the address strobe and the lower data strobe both low, the input-port select is low for 0x600000–0x6FFFFF (including 0x600001), the output-port select for 0x700000–0x7FFFFF (including 0x700001), and the serial-controller select for 0x800000–0x8FFFFF. At most one region select is active at any time.
- R6: For a decoded access with wait setting W (0–3), data acknowledge goes low at the (W+1)th rising clock edge that samples the address strobe low, and stays low while the strobe stays low.
- R7: Data acknowledge and bus error return high at the first rising edge that samples the address strobe high.
- R8: An access outside every region never drives data acknowledge low.
- R9: Bus error goes low at the 64th consecutive rising edge that samples the address strobe low, for mapped and unmapped addresses alike, and stays low until R7 releases it.
- R10: The baud enable is high for exactly one clock out of every 52. Counting rising edges since reset release as n, it is high after edge n exactly when n mod 52 equals 51.
- R11: While reset is low, data acknowledge and bus error are high and the baud enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 23 | Bus address lines A23..A1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper (even) data strobe, active low |
| lds_n | input | 1 | Lower (odd) data strobe, active low |
| rw | input | 1 | High for read, low for write |
| wait_cfg | input | 2 | Number of wait states before acknowledge |
| flash_cs_even_n | output | 1 | Flash even-lane select |
| flash_cs_odd_n | output | 1 | Flash odd-lane select |
| flash_oe_n | output | 1 | Flash output enable |
| sram_cs_even_n | output | 1 | SRAM even-lane select |
| sram_cs_odd_n | output | 1 | SRAM odd-lane select |
| sram_oe_n | output | 1 | SRAM output enable |
| sram_we_even_n | output | 1 | SRAM even-lane write enable |
| sram_we_odd_n | output | 1 | SRAM odd-lane write enable |
| in_port_sel_n | output | 1 | Input port select |
| out_port_sel_n | output | 1 | Output port select |
| uart_sel_n | output | 1 | Serial controller select |
| dtack_n | output | 1 | Data acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |
| uart_clk_en | output | 1 | One-clock 16x baud enable |

## Verification
The bench builds the block with its default parameters: a 64-clock timeout, dividers of 13 and 4, and a 2-bit wait field. This lets the 52-clock baud period repeat many times in a short run. It also lets one held strobe cross the full bus-error window, and lets all four wait settings be driven through the input port. A behavioural model tracks the strobe-low edge count and the edge count since reset. It compares every output against that model on every clock. The accesses cover each lane combination, both directions, each region edge, an unmapped address, and long-held strobes.

// File: rtl/bus_glue_ctl.sv
module bus_glue_ctl #(
  parameter int TIMEOUT = 64,
  parameter int DIV_A   = 13,
  parameter int DIV_B   = 4,
  parameter int WS_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [23:1]     addr,
  input  logic            as_n,
  input  logic            uds_n,
  input  logic            lds_n,
  input  logic            rw,
  input  logic [WS_W-1:0] wait_cfg,
  output logic            flash_cs_even_n,
  output logic            flash_cs_odd_n,
  output logic            flash_oe_n,
  output logic            sram_cs_even_n,
  output logic            sram_cs_odd_n,
  output logic            sram_oe_n,
  output logic            sram_we_even_n,
  output logic            sram_we_odd_n,
  output logic            in_port_sel_n,
  output logic            out_port_sel_n,
  output logic            uart_sel_n,
  output logic            dtack_n,
  output logic            berr_n,
  output logic            uart_clk_en
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam int AW = $clog2(DIV_A);
  localparam int BW = (DIV_B > 1) ? $clog2(DIV_B) : 1;

  logic as, ev, od;
  logic in_flash, in_sram, in_inp, in_outp, in_uart, hit;

  assign as = ~as_n;
  assign ev = as & ~uds_n;
  assign od = as & ~lds_n;

  assign in_flash = (addr[23:19] == 5'b00000);
  assign in_sram  = (addr[23:19] == 5'b00010);
  assign in_inp   = (addr[23:20] == 4'h6);
  assign in_outp  = (addr[23:20] == 4'h7);
  assign in_uart  = (addr[23:20] == 4'h8);
  assign hit      = in_flash | in_sram | in_inp | in_outp | in_uart;

  assign flash_cs_even_n = ~(ev & in_flash);
  assign flash_cs_odd_n  = ~(od & in_flash);
  assign flash_oe_n      = ~(as & in_flash & rw);
  assign sram_cs_even_n  = ~(ev & in_sram);
  assign sram_cs_odd_n   = ~(od & in_sram);
  assign sram_oe_n       = ~(as & in_sram & rw);
  assign sram_we_even_n  = ~(ev & in_sram & ~rw);
  assign sram_we_odd_n   = ~(od & in_sram & ~rw);
  assign in_port_sel_n   = ~(od & in_inp);
  assign out_port_sel_n  = ~(od & in_outp);
  assign uart_sel_n      = ~(od & in_uart);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      dtack_n <= 1'b1;
      berr_n  <= 1'b1;
    end else if (as_n) begin
      low_cnt <= '0;
      dtack_n <= 1'b1;
      berr_n  <= 1'b1;
    end else begin
      if (low_cnt != CW'(TIMEOUT))
        low_cnt <= low_cnt + 1'b1;
      if (hit && (low_cnt >= CW'(wait_cfg)))
        dtack_n <= 1'b0;
      if (low_cnt == CW'(TIMEOUT - 1))
        berr_n <= 1'b0;
    end
  end

  logic [AW-1:0] div_a;
  logic [BW-1:0] div_b;
  logic          a_wrap;

  assign a_wrap = (div_a == AW'(DIV_A - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_a <= '0;
      div_b <= '0;
    end else begin
      div_a <= a_wrap ? '0 : div_a + 1'b1;
      if (a_wrap)
        div_b <= (div_b == BW'(DIV_B - 1)) ? '0 : div_b + 1'b1;
    end
  end

  assign uart_clk_en = a_wrap && (div_b == BW'(DIV_B - 1));

  AST_DTACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(!as_n && hit)); // R8
  AST_DTACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(as_n) |-> (dtack_n && berr_n)); // R7
  AST_BERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_n && !as_n) |=> !berr_n); // R9
  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~flash_oe_n | ~flash_cs_odd_n | ~flash_cs_even_n,
              ~sram_oe_n | ~sram_we_even_n | ~sram_we_odd_n,
              ~in_port_sel_n, ~out_port_sel_n, ~uart_sel_n})); // R5
  AST_WE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_even_n || !sram_we_odd_n) |-> (!rw && sram_oe_n)); // R4
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    uart_clk_en |=> !uart_clk_en); // R10
endmodule

// File: tb/sim_bus_glue_ctl.sv
module sim_bus_glue_ctl;
  logic clk = 0, rst_n = 0;
  logic [23:1] addr = '0;
  logic as_n = 1, uds_n = 1, lds_n = 1, rw = 1;
  logic [1:0] wait_cfg = 0;
  logic fce, fco, foe, sce, sco, soe, swe, swo, ips, ops, usel, dtk, ber, ten;

  bus_glue_ctl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rw(rw), .wait_cfg(wait_cfg),
    .flash_cs_even_n(fce), .flash_cs_odd_n(fco), .flash_oe_n(foe),
    .sram_cs_even_n(sce), .sram_cs_odd_n(sco), .sram_oe_n(soe),
    .sram_we_even_n(swe), .sram_we_odd_n(swo), .in_port_sel_n(ips),
    .out_port_sel_n(ops), .uart_sel_n(usel), .dtack_n(dtk), .berr_n(ber),
    .uart_clk_en(ten));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int low_edges = 0, edges = 0;
  logic m_dtk = 1, m_ber = 1;
  int dtk_seen = 0, ber_seen = 0, tick_seen = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic int byte_addr();
    return int'({addr, 1'b0});
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      low_edges = 0; edges = 0; m_dtk = 1; m_ber = 1;
    end else begin
      int a;
      bit mapped;
      a = byte_addr();
      mapped = (a < 'h80000) || (a >= 'h100000 && a < 'h180000) ||
               (a >= 'h600000 && a < 'h900000);
      edges++;
      if (as_n) begin
        low_edges = 0; m_dtk = 1; m_ber = 1;
      end else begin
        low_edges++;
        if (mapped && low_edges >= int'(wait_cfg) + 1) m_dtk = 0;
        if (low_edges >= 64) m_ber = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R11 dtack in reset", dtk, 1'b1);
      chk("R11 berr in reset", ber, 1'b1);
      chk("R11 tick in reset", ten, 1'b0);
    end else begin
      int a;
      bit s, e, o, fl, sr, rd;
      a = byte_addr();
      s = !as_n; e = s && !uds_n; o = s && !lds_n; rd = rw;
      fl = a < 'h80000;
      sr = a >= 'h100000 && a < 'h180000;
      chk("R1 flash even", fce, !(e && fl));
      chk("R1 flash odd", fco, !(o && fl));
      chk("R2 flash oe", foe, !(s && fl && rd));
      chk("R3 sram even", sce, !(e && sr));
      chk("R3 sram odd", sco, !(o && sr));
      chk("R3 sram oe", soe, !(s && sr && rd));
      chk("R4 sram we even", swe, !(e && sr && !rd));
      chk("R4 sram we odd", swo, !(o && sr && !rd));
      chk("R5 input sel", ips, !(o && a >= 'h600000 && a < 'h700000));
      chk("R5 output sel", ops, !(o && a >= 'h700000 && a < 'h800000));
      chk("R5 uart sel", usel, !(o && a >= 'h800000 && a < 'h900000));
      chk("R6 R7 R8 dtack", dtk, m_dtk);
      chk("R9 berr", ber, m_ber);
      chk("R10 baud enable", ten, (edges % 52) == 51);
      if (!dtk) dtk_seen++;
      if (!ber) ber_seen++;
      if (ten) tick_seen++;
    end
  end

  task automatic access(input int a, input logic u, input logic l,
                        input logic r, input logic [1:0] w, input int hold);
    @(posedge clk); #1;
    addr = a[23:1]; rw = r; wait_cfg = w; as_n = 0; uds_n = u; lds_n = l;
    repeat (hold) @(posedge clk);
    #1; as_n = 1; uds_n = 1; lds_n = 1; rw = 1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int w = 0; w < 4; w++) begin
      access('h000000, 0, 0, 1, 2'(w), 6);   // R1 R2 word read
      access('h07FFFE, 1, 0, 1, 2'(w), 6);   // R1 top of flash
      access('h000010, 0, 1, 0, 2'(w), 6);   // R2 write: no oe
      access('h100000, 0, 1, 1, 2'(w), 6);   // R3 even read
      access('h17FFFE, 1, 0, 0, 2'(w), 6);   // R4 odd write
      access('h13FF00, 0, 0, 0, 2'(w), 6);   // R4 word write
      access('h600001, 1, 0, 1, 2'(w), 6);   // R5 input port
      access('h700001, 1, 0, 0, 2'(w), 6);   // R5 output port
      access('h800001, 1, 0, 1, 2'(w), 6);   // R5 uart
      access('h080000, 0, 0, 1, 2'(w), 6);   // R8 gap after flash
      access('h300000, 0, 0, 1, 2'(w), 6);   // R8 unmapped
    end
    access('h600000, 0, 1, 1, 0, 5);        // R5 even strobe only: no sel
    access('h300000, 0, 0, 1, 0, 70);       // R9 unmapped timeout
    access('h100000, 0, 0, 0, 3, 70);       // R9 mapped held strobe
    repeat (120) @(posedge clk);
    @(negedge clk); #1;
    checks++;
    if (dtk_seen == 0 || ber_seen == 0 || tick_seen < 10) begin
      errors++;
      $display("FAIL R6 R9 R10 coverage: dtack %0d berr %0d ticks %0d expected nonzero/10",
               dtk_seen, ber_seen, tick_seen);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule